// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order integer core with five stages: fetch, decode, execute, memory access and writeback. It holds 32 general registers of 32 bits, an instruction store of 256 words (1 KB), and a word-addressed data store of 64 words. Before a run, a host writes the program through a word-wide write port while reset is held. It then raises `start` and reads the registers and data words back through two combinational debug ports. While `start` is low the whole pipeline is frozen.

The core executes and, xor, sll, add, sub, mul, addi, srai, lw, sw and beq. Results of older instructions that are still in flight are forwarded into the execute stage. A load followed at once by a user of its result costs one stall cycle. Branches are decided in decode by comparing the two register values, and a taken branch discards the instruction fetched behind it. Decode gets no forwarding, so a branch operand must come from an instruction at least three slots earlier. The register file hands a value written in writeback straight to a decode read of the same register in the same cycle.

Top module: `rv5_pipe`

## Requirements
- R1: All instructions use opcode bits [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20] and funct7 [31:25].
  - Register ops use opcode 0110011. With funct7 0000000: add (funct3 000), sll (001), xor (100) and and (111). sub is funct7 0100000 with funct3 000. mul is funct7 0000001 with funct3 000 and writes the low 32 bits of the product.
  - Immediate ops use opcode 0010011. addi is funct3 000 with a sign-extended 12-bit immediate. srai is funct3 101 with funct7 0100000 and shifts arithmetically by bits [24:20].
  - sll shifts by the low 5 bits of rs2.
- R2: lw (opcode 0000011, funct3 010) and sw (opcode 0100011, funct3 010) access word ((rs1 + offset) >> 2) mod 64.
  - The load offset is bits [31:20].
  - The store offset is {[31:25],[11:7]}.
  - Both offsets are sign-extended.
- R3: beq (opcode 1100011, funct3 000) is decided in decode.
  - When rs1 equals rs2, the next PC is the branch PC plus the sign-extended offset {[31],[7],[30:25],[11:8],0}. Otherwise the next PC is PC+4.
  - A taken branch turns the instruction fetched behind it into a no-op, so that instruction has no effect.
- R4: Each execute operand uses a 2-bit source select: 00 takes the register value, 10 takes the memory-stage ALU result, and 01 takes the writeback value.
  - The memory-stage source wins when both stages write the same nonzero register.
- R5: When the instruction in execute is a load whose rd matches rs1 or rs2 of the instruction in decode, the PC and the fetch/decode register hold for one cycle and a bubble with all controls zero enters execute.
- R6: Reset clears the PC, all registers and all data words to zero, and loads every pipeline register with a no-op.
- R7: While `start` is low no register, data word or PC changes.
- R8: x0 reads as zero, writes to it are dropped, and it is never forwarded.
- R9: A decode read of the register being written back in the same cycle returns the new value.
- R10: The instruction write port stores word `imem_wdata` at word index `imem_waddr`. `dbg_reg_val` and `dbg_mem_val` show the selected register and data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pipeline advance enable |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 8 | Instruction word index |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_reg_sel | input | 5 | Register to show |
| dbg_reg_val | output | 32 | Selected register value |
| dbg_mem_sel | input | 6 | Data word to show |
| dbg_mem_val | output | 32 | Selected data word |

## Verification
The bench aims at adjacent writers of the same register, where the newer result must win; a priority error leaves the older value in the sum. It stores a just-loaded value and uses loads back to back; a missing stall would consume stale data, and missing forwarding on the store path would write the wrong word. A countdown loop with taken branches both ways checks that the discarded instruction behind each branch never writes, and its exit test reads a value three slots old, which fails without the same-cycle writeback bypass. Writes to x0 followed by reads of x0 check that the zero register is never forwarded.

// File: rtl/rv5_pipe.sv
module rv5_pipe #(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            imem_we,
  input  logic [IA_W-1:0] imem_waddr,
  input  logic [31:0]     imem_wdata,
  input  logic [4:0]      dbg_reg_sel,
  output logic [31:0]     dbg_reg_val,
  input  logic [DA_W-1:0] dbg_mem_sel,
  output logic [31:0]     dbg_mem_val
);
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_XOR = 3'd3,
                         OP_SLL = 3'd4, OP_MUL = 3'd5, OP_SRA = 3'd6;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf [32];

  // fetch
  logic [31:0] pc, if_ir;
  logic [31:0] id_pc, id_ir;

  // decode
  logic [6:0] d_op, d_f7;
  logic [2:0] d_f3;
  logic [4:0] d_rs1, d_rs2, d_rd;
  logic d_rw, d_mw, d_mr, d_src, d_beq;
  logic [2:0] d_alu;
  logic [31:0] imm_i, imm_s, imm_b, d_imm, rv1, rv2;
  logic stall, taken;

  // execute
  logic ex_rw, ex_mr, ex_mw, ex_src;
  logic [2:0] ex_alu;
  logic [4:0] ex_rs1, ex_rs2, ex_rd;
  logic [31:0] ex_a, ex_b, ex_imm;
  logic [1:0] fwd_a, fwd_b;
  logic [31:0] opa, opb_reg, opb, alu_y;

  // memory
  logic mem_rw, mem_mw, mem_m2r;
  logic [4:0] mem_rd;
  logic [31:0] mem_alu, mem_sd, mem_rdata;

  // writeback
  logic wb_rw, wb_m2r, wb_we;
  logic [4:0] wb_rd;
  logic [31:0] wb_alu, wb_md, wb_val;

  always_ff @(posedge clk)
    if (imem_we) imem[imem_waddr] <= imem_wdata;

  assign if_ir = imem[pc[IA_W+1:2]];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      id_pc <= '0;
      id_ir <= NOP;
    end else if (start && !stall) begin
      pc <= taken ? id_pc + imm_b : pc + 32'd4;
      id_pc <= pc;
      id_ir <= taken ? NOP : if_ir;
    end
  end

  assign d_op  = id_ir[6:0];
  assign d_rd  = id_ir[11:7];
  assign d_f3  = id_ir[14:12];
  assign d_rs1 = id_ir[19:15];
  assign d_rs2 = id_ir[24:20];
  assign d_f7  = id_ir[31:25];
  assign imm_i = {{20{id_ir[31]}}, id_ir[31:20]};
  assign imm_s = {{20{id_ir[31]}}, id_ir[31:25], id_ir[11:7]};
  assign imm_b = {{19{id_ir[31]}}, id_ir[31], id_ir[7], id_ir[30:25], id_ir[11:8], 1'b0};
  assign d_imm = d_mw ? imm_s : imm_i;

  always_comb begin
    d_rw = 1'b0; d_mw = 1'b0; d_mr = 1'b0; d_src = 1'b0; d_beq = 1'b0; d_alu = OP_ADD;
    case (d_op)
      7'b0110011: begin
        if (d_f7 == 7'b0000000) begin
          d_rw = (d_f3 == 3'b000) || (d_f3 == 3'b001) || (d_f3 == 3'b100) || (d_f3 == 3'b111);
          case (d_f3)
            3'b001:  d_alu = OP_SLL;
            3'b100:  d_alu = OP_XOR;
            3'b111:  d_alu = OP_AND;
            default: d_alu = OP_ADD;
          endcase
        end else if (d_f7 == 7'b0100000 && d_f3 == 3'b000) begin
          d_rw = 1'b1; d_alu = OP_SUB;
        end else if (d_f7 == 7'b0000001 && d_f3 == 3'b000) begin
          d_rw = 1'b1; d_alu = OP_MUL;
        end
      end
      7'b0010011: begin
        if (d_f3 == 3'b000) begin
          d_rw = 1'b1; d_src = 1'b1;
        end else if (d_f3 == 3'b101 && d_f7 == 7'b0100000) begin
          d_rw = 1'b1; d_src = 1'b1; d_alu = OP_SRA;
        end
      end
      7'b0000011: if (d_f3 == 3'b010) begin
        d_rw = 1'b1; d_mr = 1'b1; d_src = 1'b1;
      end
      7'b0100011: if (d_f3 == 3'b010) begin
        d_mw = 1'b1; d_src = 1'b1;
      end
      7'b1100011: d_beq = (d_f3 == 3'b000);
      default: ;
    endcase
  end

  assign wb_val = wb_m2r ? wb_md : wb_alu;
  assign wb_we  = start && wb_rw && (wb_rd != 5'd0);
  assign rv1 = (d_rs1 == 5'd0) ? '0 : (wb_we && wb_rd == d_rs1) ? wb_val : rf[d_rs1];
  assign rv2 = (d_rs2 == 5'd0) ? '0 : (wb_we && wb_rd == d_rs2) ? wb_val : rf[d_rs2];

  assign stall = ex_mr && (ex_rd != 5'd0) && ((ex_rd == d_rs1) || (ex_rd == d_rs2));
  assign taken = d_beq && (rv1 == rv2) && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_rw <= 1'b0; ex_mr <= 1'b0; ex_mw <= 1'b0; ex_src <= 1'b0; ex_alu <= OP_ADD;
      ex_rs1 <= '0; ex_rs2 <= '0; ex_rd <= '0; ex_a <= '0; ex_b <= '0; ex_imm <= '0;
    end else if (start) begin
      ex_rw  <= stall ? 1'b0 : d_rw;
      ex_mr  <= stall ? 1'b0 : d_mr;
      ex_mw  <= stall ? 1'b0 : d_mw;
      ex_src <= stall ? 1'b0 : d_src;
      ex_alu <= stall ? OP_ADD : d_alu;
      ex_rs1 <= d_rs1; ex_rs2 <= d_rs2; ex_rd <= d_rd;
      ex_a <= rv1; ex_b <= rv2; ex_imm <= d_imm;
    end
  end

  assign fwd_a = (mem_rw && mem_rd != 5'd0 && mem_rd == ex_rs1) ? 2'b10 :
                 (wb_rw && wb_rd != 5'd0 && wb_rd == ex_rs1) ? 2'b01 : 2'b00;
  assign fwd_b = (mem_rw && mem_rd != 5'd0 && mem_rd == ex_rs2) ? 2'b10 :
                 (wb_rw && wb_rd != 5'd0 && wb_rd == ex_rs2) ? 2'b01 : 2'b00;

  always_comb begin
    case (fwd_a)
      2'b10:   opa = mem_alu;
      2'b01:   opa = wb_val;
      default: opa = ex_a;
    endcase
    case (fwd_b)
      2'b10:   opb_reg = mem_alu;
      2'b01:   opb_reg = wb_val;
      default: opb_reg = ex_b;
    endcase
  end
  assign opb = ex_src ? ex_imm : opb_reg;

  always_comb begin
    case (ex_alu)
      OP_SUB:  alu_y = opa - opb;
      OP_AND:  alu_y = opa & opb;
      OP_XOR:  alu_y = opa ^ opb;
      OP_SLL:  alu_y = opa << opb[4:0];
      OP_MUL:  alu_y = opa * opb;
      OP_SRA:  alu_y = $signed(opa) >>> opb[4:0];
      default: alu_y = opa + opb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rw <= 1'b0; mem_mw <= 1'b0; mem_m2r <= 1'b0; mem_rd <= '0; mem_alu <= '0; mem_sd <= '0;
    end else if (start) begin
      mem_rw <= ex_rw; mem_mw <= ex_mw; mem_m2r <= ex_mr; mem_rd <= ex_rd;
      mem_alu <= alu_y; mem_sd <= opb_reg;
    end
  end

  assign mem_rdata = dmem[mem_alu[DA_W+1:2]];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (start && mem_mw) begin
      dmem[mem_alu[DA_W+1:2]] <= mem_sd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_rw <= 1'b0; wb_m2r <= 1'b0; wb_rd <= '0; wb_alu <= '0; wb_md <= '0;
    end else if (start) begin
      wb_rw <= mem_rw; wb_m2r <= mem_m2r; wb_rd <= mem_rd; wb_alu <= mem_alu; wb_md <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (wb_we) begin
      rf[wb_rd] <= wb_val;
    end
  end

  assign dbg_reg_val = rf[dbg_reg_sel];
  assign dbg_mem_val = dmem[dbg_mem_sel];

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00); // R3
  AST_FLUSH_AFTER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    start && taken |=> id_ir == NOP); // R3
  AST_FWD_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fwd_a != 2'b11 && fwd_b != 2'b11); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    start && stall |=> pc == $past(pc) && id_ir == $past(id_ir)); // R5
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    start && stall |=> !ex_rw && !ex_mw && !ex_mr); // R5
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(pc) && $stable(id_ir) && $stable(mem_alu)); // R7
  AST_X0_ZERO: assert property (@(posedge clk) disable iff (rst) rf[0] == 32'd0); // R8
endmodule

// File: tb/rv5_pipe_test.sv
`timescale 1ns/1ps
module rv5_pipe_test;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, imem_we = 1'b0;
  logic [7:0] imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0] dbg_reg_sel = '0;
  logic [5:0] dbg_mem_sel = '0;
  logic [31:0] dbg_reg_val, dbg_mem_val;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rv5_pipe uut (.clk(clk), .rst(rst), .start(start), .imem_we(imem_we), .imem_waddr(imem_waddr),
                .imem_wdata(imem_wdata), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
                .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val));

  logic [31:0] prog[$];
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] snap_r [32];
  logic [31:0] snap_m [64];

  function automatic logic [31:0] r_t(int f7, int rs2, int rs1, int f3, int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] i_t(int imm, int rs1, int f3, int rd, int op);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
  endfunction
  function automatic logic [31:0] s_t(int imm, int rs2, int rs1);
    logic [11:0] m = 12'(imm);
    return {m[11:5], 5'(rs2), 5'(rs1), 3'b010, m[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] b_t(int imm, int rs1, int rs2);
    logic [12:0] m = 13'(imm);
    return {m[12], m[10:5], 5'(rs2), 5'(rs1), 3'b000, m[4:1], m[11], 7'h63};
  endfunction
  function automatic logic [31:0] addi(int rd, int rs, int imm); return i_t(imm, rs, 0, rd, 'h13); endfunction
  function automatic logic [31:0] srai(int rd, int rs, int sh); return i_t(32'h400 | sh, rs, 5, rd, 'h13); endfunction
  function automatic logic [31:0] lw(int rd, int rs, int imm); return i_t(imm, rs, 2, rd, 'h03); endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run_model(output int steps);
    logic [31:0] pc = 0, ir, a, b, ii, is, ib;
    int rd;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    for (int i = 0; i < 64; i++) mmem[i] = 0;
    steps = 0;
    while (steps < 2000) begin
      ir = prog[pc >> 2];
      rd = int'(ir[11:7]);
      a = mreg[ir[19:15]]; b = mreg[ir[24:20]];
      ii = {{20{ir[31]}}, ir[31:20]};
      is = {{20{ir[31]}}, ir[31:25], ir[11:7]};
      ib = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
      steps++;
      if (ir[6:0] == 7'h63) begin
        if (a == b) begin
          if (ib == 0) break;
          pc = pc + ib;
        end else pc = pc + 4;
        continue;
      end
      case (ir[6:0])
        7'h33: case ({ir[31:25], ir[14:12]})
          10'b0000000_000: mreg[rd] = a + b;
          10'b0100000_000: mreg[rd] = a - b;
          10'b0000001_000: mreg[rd] = a * b;
          10'b0000000_111: mreg[rd] = a & b;
          10'b0000000_100: mreg[rd] = a ^ b;
          10'b0000000_001: mreg[rd] = a << b[4:0];
          default: ;
        endcase
        7'h13: if (ir[14:12] == 0) mreg[rd] = a + ii;
               else if (ir[14:12] == 5) mreg[rd] = $signed(a) >>> ir[24:20];
        7'h03: mreg[rd] = mmem[((a + ii) >> 2) & 63];
        7'h23: mmem[((a + is) >> 2) & 63] = b;
        default: ;
      endcase
      mreg[0] = 0;
      pc = pc + 4;
    end
  endtask

  task automatic load_prog();
    rst = 1'b1; start = 1'b0;
    foreach (prog[i]) begin
      @(negedge clk); imem_we = 1'b1; imem_waddr = 8'(i); imem_wdata = prog[i];
    end
    @(negedge clk); imem_we = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic compare_all(string tag);
    for (int r = 0; r < 32; r++) begin
      dbg_reg_sel = 5'(r); #0.1;
      check(tag, $sformatf("x%0d", r), dbg_reg_val, mreg[r]);
    end
    for (int m = 0; m < 64; m++) begin
      dbg_mem_sel = 6'(m); #0.1;
      check(tag, $sformatf("mem[%0d]", m), dbg_mem_val, mmem[m]);
    end
  endtask

  task automatic take_snap();
    for (int r = 0; r < 32; r++) begin dbg_reg_sel = 5'(r); #0.1; snap_r[r] = dbg_reg_val; end
    for (int m = 0; m < 64; m++) begin dbg_mem_sel = 6'(m); #0.1; snap_m[m] = dbg_mem_val; end
  endtask

  task automatic run_prog(string tag, int pause_at);
    int steps;
    run_model(steps);
    load_prog();
    start = 1'b1;
    if (pause_at > 0) begin
      repeat (pause_at) @(negedge clk);
      start = 1'b0;
      take_snap();
      repeat (20) @(negedge clk);
      // R7: frozen pipeline leaves every register and data word untouched
      for (int r = 0; r < 32; r++) begin
        dbg_reg_sel = 5'(r); #0.1; check("R7", $sformatf("frozen x%0d", r), dbg_reg_val, snap_r[r]);
      end
      for (int m = 0; m < 64; m++) begin
        dbg_mem_sel = 6'(m); #0.1; check("R7", $sformatf("frozen mem[%0d]", m), dbg_mem_val, snap_m[m]);
      end
      @(negedge clk); start = 1'b1;
    end
    repeat (steps * 3 + 20) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R6: reset state before anything runs
    repeat (3) @(negedge clk);
    for (int r = 0; r < 32; r++) begin dbg_reg_sel = 5'(r); #0.1; check("R6", "initial reg", dbg_reg_val, 0); end

    // R1/R4/R8/R10 arithmetic, forwarding priority, x0, with a pause for R7
    prog.delete();
    prog.push_back(addi(1, 0, 10));
    prog.push_back(addi(2, 0, -3));
    prog.push_back(r_t(0, 2, 1, 0, 3));
    prog.push_back(r_t('h20, 1, 3, 0, 4));
    prog.push_back(r_t(0, 1, 4, 4, 5));
    prog.push_back(r_t(0, 3, 5, 7, 6));
    prog.push_back(r_t(0, 2, 1, 1, 7));
    prog.push_back(r_t(1, 2, 1, 0, 8));
    prog.push_back(srai(9, 2, 1));
    prog.push_back(addi(11, 0, 5));
    prog.push_back(addi(11, 0, 7));
    prog.push_back(r_t(0, 11, 11, 0, 12));
    prog.push_back(addi(0, 0, 99));
    prog.push_back(r_t(0, 1, 0, 0, 13));
    prog.push_back(addi(14, 0, -1000));
    prog.push_back(r_t(1, 14, 14, 0, 15));
    prog.push_back(r_t(1, 15, 15, 0, 16));
    prog.push_back(srai(17, 16, 4));
    prog.push_back(r_t(0, 9, 16, 1, 18));
    prog.push_back(b_t(0, 0, 0));
    run_prog("R1/R4/R8/R10", 7);

    // R2/R5 loads, stores, load-use stalls, store of a just-loaded value
    prog.delete();
    prog.push_back(addi(1, 0, 8));
    prog.push_back(addi(2, 0, 123));
    prog.push_back(s_t(4, 2, 1));
    prog.push_back(lw(3, 1, 4));
    prog.push_back(r_t(0, 3, 3, 0, 4));
    prog.push_back(s_t(-4, 3, 1));
    prog.push_back(lw(5, 1, -4));
    prog.push_back(s_t(0, 5, 0));
    prog.push_back(lw(6, 0, 0));
    prog.push_back(addi(7, 6, 1));
    prog.push_back(lw(8, 0, 12));
    prog.push_back(addi(0, 0, 0));
    prog.push_back(r_t(0, 1, 8, 0, 9));
    prog.push_back(addi(10, 0, -4));
    prog.push_back(s_t(252, 10, 0));
    prog.push_back(lw(11, 0, 252));
    prog.push_back(r_t('h20, 9, 11, 0, 12));
    prog.push_back(b_t(0, 0, 0));
    run_prog("R2/R5", 0);

    // R3/R9 countdown loop with taken branches both ways and flushed slots
    prog.delete();
    prog.push_back(addi(1, 0, 3));
    prog.push_back(addi(0, 0, 0));
    prog.push_back(addi(0, 0, 0));
    prog.push_back(addi(2, 2, 5));
    prog.push_back(addi(1, 1, -1));
    prog.push_back(addi(0, 0, 0));
    prog.push_back(addi(0, 0, 0));
    prog.push_back(b_t(12, 1, 0));
    prog.push_back(b_t(-20, 0, 0));
    prog.push_back(addi(3, 0, 77));
    prog.push_back(addi(4, 0, 1));
    prog.push_back(b_t(8, 2, 0));
    prog.push_back(addi(5, 0, 9));
    prog.push_back(b_t(0, 0, 0));
    run_prog("R3/R9", 0);

    // R6: reset after a run clears registers and data words
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int r = 0; r < 32; r++) begin dbg_reg_sel = 5'(r); #0.1; check("R6", "reset reg", dbg_reg_val, 0); end
    for (int m = 0; m < 64; m++) begin dbg_mem_sel = 6'(m); #0.1; check("R6", "reset mem", dbg_mem_val, 0); end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule